// File: doc/BRIEF.md
# USB Host Root-Port Control and Suspend Wake

This block holds the register side of a simple USB host controller: a command register, a status register and one control word for each root port. Software reaches all of them through a 32-byte register window on a plain read/write bus. Only the low five address bits are decoded, so the window repeats at every higher address. The block records device connect and disconnect events reported by the root ports. When software sets a port's reset bit, the block sends a one-cycle reset request to that port. It also drives one interrupt line.

The controller can be placed in global suspend. While it is suspended, any connect or disconnect on any root port wakes it. The block sets the force-resume command bit and the resume-detect status bit, and the interrupt is raised if enabled. The port's own change bits are updated as usual. Schedule processing and bus signalling are handled elsewhere. The interrupt-enable mask comes in as an input.

Top module: `usbh_portctl_regs`

## Requirements
- R1: After reset, the command register, the status register and every port word read 0, and the interrupt and all reset requests are low.
- R2: Only address bits [4:0] are decoded. Bit 0 is ignored. The command register is at 0x00, the status register at 0x02, and port n at 0x10+2n. Any other offset, including a port index at or above NPORTS, reads RD_DEFAULT (0xFFFF), and writes to it change nothing.
- R3: Command bits are: 0 run, 1 controller reset, 2 global reset, 3 suspend enable, 4 force resume. Bits 0, 2, 3 and 4 read back as written, and bits 15:5 read 0. A write with bit 1 set clears the command, status and port registers at that edge, so they read 0 from the next cycle.
- R4: A port write that sets bit 9 (reset) while the stored bit 9 is clear makes that port's reset request high for exactly the one cycle after the write. Writing bit 9 again while it is already set gives no pulse.
- R5: An attach sets port bit 0 (connected) and bit 1 (connect change). It copies the low-speed flag into bit 8.
- R6: A detach clears bit 0 and sets bit 1. If bit 2 (enabled) is set, the detach clears it and sets bit 3 (enable change); otherwise bit 3 is unchanged.
- R7: If command bit 3 is set when any port sees an attach or detach, command bit 4 and status bit 2 (resume detect) become set. With bit 3 clear, neither changes.
- R8: Status bits and port bits 1 and 3 are write-1-to-clear. Writing 0 to them leaves them unchanged, and a wake event in the same cycle wins over a clear.
- R9: The interrupt is high exactly when some status bit [3:0] and the matching interrupt-enable bit are both set.
- R10: Port bits 2 and 9 are written directly. Port bits 0 and 8 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when set together with bus_sel |
| bus_addr | input | ADDR_W | Register address; low five bits decoded |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data for bus_addr |
| dev_attach | input | NPORTS | One-cycle connect event per port |
| dev_detach | input | NPORTS | One-cycle disconnect event per port |
| dev_lowspeed | input | NPORTS | Low-speed flag, sampled with an attach |
| irq_enable | input | 4 | Interrupt mask for status bits [3:0] |
| port_reset_req | output | NPORTS | One-cycle reset request per port |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that no port sees an attach and a detach in the same cycle. They also treat a port write that coincides with a detach as outside the detach property, because the written enable bit then decides the outcome. The stimulus never raises both event pulses on one port together. It mixes random writes at all window offsets, with random upper address bits, with random event pulses. Controller-reset writes are kept rare so that state can build up between them.

// File: rtl/usbh_pkg.sv
`timescale 1ns/1ps
package usbh_pkg;
   localparam int WIN_BITS   = 5;
   localparam int CMD_W      = 5;
   localparam int STS_W      = 4;
   localparam int CMD_RUN    = 0;
   localparam int CMD_HCRST  = 1;
   localparam int CMD_GRST   = 2;
   localparam int CMD_SUSP   = 3;
   localparam int CMD_FRES   = 4;
   localparam int STS_RESUME = 2;
   localparam int P_CONN     = 0;
   localparam int P_CCHG     = 1;
   localparam int P_EN       = 2;
   localparam int P_ECHG     = 3;
   localparam int P_LS       = 8;
   localparam int P_RST      = 9;

   typedef struct packed {
      logic rst;
      logic ls;
      logic echg;
      logic en;
      logic cchg;
      logic conn;
   } port_state_t;
endpackage

// File: rtl/usbh_cmd_sts.sv
`timescale 1ns/1ps
module usbh_cmd_sts
   import usbh_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_wr,
   input  logic                 sts_wr,
   input  logic [REG_W-1:0]     wdata,
   input  logic                 wake,
   output logic [CMD_W-1:0]     cmd_q,
   output logic [STS_W-1:0]     sts_q,
   output logic                 hc_reset
);
   logic [CMD_W-1:0] cmd_n;
   logic [STS_W-1:0] sts_n;
   logic             unused_wd;

   assign hc_reset  = cmd_wr & wdata[CMD_HCRST];
   assign unused_wd = ^wdata[REG_W-1:CMD_W];

   always_comb begin
      cmd_n = cmd_q;
      sts_n = sts_q;
      if (cmd_wr) cmd_n = wdata[CMD_W-1:0];
      if (sts_wr) sts_n = sts_q & ~wdata[STS_W-1:0];
      // wake from global suspend: takes priority over the clear
      if (wake && cmd_q[CMD_SUSP]) begin
         cmd_n[CMD_FRES]   = 1'b1;
         sts_n[STS_RESUME] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
         sts_q <= '0;
      end else if (hc_reset) begin
         cmd_q <= '0;
         sts_q <= '0;
      end else begin
         cmd_q <= cmd_n;
         sts_q <= sts_n;
      end
   end
endmodule

// File: rtl/usbh_port_reg.sv
`timescale 1ns/1ps
module usbh_port_reg
   import usbh_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             attach,
   input  logic             detach,
   input  logic             lowspeed,
   output logic [REG_W-1:0] word,
   output logic             rst_req
);
   port_state_t st_q, st_n;
   logic        unused_wd;

   assign unused_wd = ^{wdata[REG_W-1:P_RST+1], wdata[P_LS:P_ECHG+1], wdata[P_CONN]};

   always_comb begin
      st_n = st_q;
      if (wr) begin
         st_n.en  = wdata[P_EN];
         st_n.rst = wdata[P_RST];
         if (wdata[P_CCHG]) st_n.cchg = 1'b0;
         if (wdata[P_ECHG]) st_n.echg = 1'b0;
      end
      if (attach) begin
         st_n.conn = 1'b1;
         st_n.cchg = 1'b1;
         st_n.ls   = lowspeed;
      end
      if (detach) begin
         st_n.conn = 1'b0;
         st_n.cchg = 1'b1;
         if (st_n.en) begin
            st_n.en   = 1'b0;
            st_n.echg = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= '0;
         rst_req <= 1'b0;
      end else if (clear) begin
         st_q    <= '0;
         rst_req <= 1'b0;
      end else begin
         st_q    <= st_n;
         rst_req <= wr & wdata[P_RST] & ~st_q.rst;
      end
   end

   always_comb begin
      word         = '0;
      word[P_CONN] = st_q.conn;
      word[P_CCHG] = st_q.cchg;
      word[P_EN]   = st_q.en;
      word[P_ECHG] = st_q.echg;
      word[P_LS]   = st_q.ls;
      word[P_RST]  = st_q.rst;
   end
endmodule

// File: rtl/usbh_rd_mux.sv
`timescale 1ns/1ps
module usbh_rd_mux
   import usbh_pkg::*;
#(
   parameter int              NPORTS     = 2,
   parameter int              REG_W      = 16,
   parameter logic [REG_W-1:0] RD_DEFAULT = '1,
   parameter bit              RDATA_FLOP = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [WIN_BITS-1:0]           addr,
   input  logic [REG_W-1:0]              cmd_word,
   input  logic [REG_W-1:0]              sts_word,
   input  logic [NPORTS-1:0][REG_W-1:0]  port_words,
   output logic [REG_W-1:0]              rdata
);
   logic [REG_W-1:0] rd_c;
   logic             unused_a0;

   assign unused_a0 = addr[0];

   always_comb begin
      rd_c = RD_DEFAULT;
      if (addr[4:1] == 4'd0)      rd_c = cmd_word;
      else if (addr[4:1] == 4'd1) rd_c = sts_word;
      else if (addr[4]) begin
         for (int n = 0; n < NPORTS; n++)
            if (addr[3:1] == 3'(n)) rd_c = port_words[n];
      end
   end

   generate
      if (RDATA_FLOP) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_c;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rdata      = rd_c;
      end
   endgenerate
endmodule

// File: rtl/usbh_portctl_regs.sv
`timescale 1ns/1ps
module usbh_portctl_regs
   import usbh_pkg::*;
#(
   parameter int               NPORTS     = 2,
   parameter int               ADDR_W     = 16,
   parameter int               REG_W      = 16,
   parameter logic [REG_W-1:0] RD_DEFAULT = '1,
   parameter bit               RDATA_FLOP = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic [NPORTS-1:0]  dev_attach,
   input  logic [NPORTS-1:0]  dev_detach,
   input  logic [NPORTS-1:0]  dev_lowspeed,
   input  logic [3:0]         irq_enable,
   output logic [NPORTS-1:0]  port_reset_req,
   output logic               irq
);
   localparam int IDX_LIMIT = 1 << (WIN_BITS - 2);

   generate
      if (NPORTS < 1 || NPORTS > IDX_LIMIT) begin : g_bad_ports
         $error("NPORTS must lie in 1..8");
      end
      if (ADDR_W <= WIN_BITS) begin : g_bad_addr
         $error("ADDR_W must exceed the window width");
      end
      if (REG_W < P_RST + 1) begin : g_bad_width
         $error("REG_W too narrow for the port word");
      end
   endgenerate

   logic [WIN_BITS-1:0]          a5;
   logic                         wr;
   logic                         cmd_wr, sts_wr, hc_reset, wake;
   logic [CMD_W-1:0]             cmd_q;
   logic [STS_W-1:0]             sts_q;
   logic [NPORTS-1:0]            port_wr;
   logic [NPORTS-1:0][REG_W-1:0] port_words;
   logic                         unused_hi;

   assign a5        = bus_addr[WIN_BITS-1:0];
   assign unused_hi = ^bus_addr[ADDR_W-1:WIN_BITS];
   assign wr        = bus_sel & bus_we;
   assign cmd_wr    = wr & (a5[4:1] == 4'd0);
   assign sts_wr    = wr & (a5[4:1] == 4'd1);
   assign wake      = |dev_attach | |dev_detach;

   usbh_cmd_sts #(.REG_W(REG_W)) u_cmd_sts (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_wr   (cmd_wr),
      .sts_wr   (sts_wr),
      .wdata    (bus_wdata),
      .wake     (wake),
      .cmd_q    (cmd_q),
      .sts_q    (sts_q),
      .hc_reset (hc_reset)
   );

   generate
      for (genvar p = 0; p < NPORTS; p++) begin : g_port
         assign port_wr[p] = wr & a5[4] & (a5[3:1] == 3'(p));
         usbh_port_reg #(.REG_W(REG_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (hc_reset),
            .wr       (port_wr[p]),
            .wdata    (bus_wdata),
            .attach   (dev_attach[p]),
            .detach   (dev_detach[p]),
            .lowspeed (dev_lowspeed[p]),
            .word     (port_words[p]),
            .rst_req  (port_reset_req[p])
         );
      end
   endgenerate

   usbh_rd_mux #(
      .NPORTS(NPORTS), .REG_W(REG_W), .RD_DEFAULT(RD_DEFAULT), .RDATA_FLOP(RDATA_FLOP)
   ) u_rd_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (a5),
      .cmd_word   ({{(REG_W-CMD_W){1'b0}}, cmd_q}),
      .sts_word   ({{(REG_W-STS_W){1'b0}}, sts_q}),
      .port_words (port_words),
      .rdata      (bus_rdata)
   );

   assign irq = |(sts_q & irq_enable);
endmodule

// File: rtl/usbh_regs_chk.sv
`timescale 1ns/1ps
module usbh_regs_chk
   import usbh_pkg::*;
#(
   parameter int NPORTS = 2,
   parameter int ADDR_W = 16,
   parameter int REG_W  = 16
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          bus_sel,
   input logic                          bus_we,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic [REG_W-1:0]              bus_wdata,
   input logic [NPORTS-1:0]             dev_attach,
   input logic [NPORTS-1:0]             dev_detach,
   input logic [NPORTS-1:0]             dev_lowspeed,
   input logic [CMD_W-1:0]              cmd_q,
   input logic [STS_W-1:0]              sts_q,
   input logic [NPORTS-1:0][REG_W-1:0]  port_words,
   input logic [NPORTS-1:0]             port_reset_req
);
   logic c_wr, c_cmd, c_sts, c_hcr, c_ev;
   assign c_wr  = bus_sel & bus_we;
   assign c_cmd = c_wr & (bus_addr[4:1] == 4'd0);
   assign c_sts = c_wr & (bus_addr[4:1] == 4'd1);
   assign c_hcr = c_cmd & bus_wdata[CMD_HCRST];
   assign c_ev  = |dev_attach | |dev_detach;

   // R3
   hc_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_hcr |=> (cmd_q == '0) && (sts_q == '0));

   // R7
   resume_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_ev && cmd_q[CMD_SUSP] && !c_hcr) |=> (cmd_q[CMD_FRES] && sts_q[STS_RESUME]));

   // R8
   sts_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_sts && bus_wdata[STS_RESUME] && !(c_ev && cmd_q[CMD_SUSP])) |=> !sts_q[STS_RESUME]);

   generate
      for (genvar p = 0; p < NPORTS; p++) begin : g_pchk
         logic p_wr;
         assign p_wr = c_wr & bus_addr[4] & (bus_addr[3:1] == 3'(p));

         // R4
         rst_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            port_reset_req[p] |=> !port_reset_req[p]);

         // R5
         attach_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_attach[p] && !c_hcr) |=> (port_words[p][P_CONN] && port_words[p][P_CCHG]
               && (port_words[p][P_LS] == $past(dev_lowspeed[p]))));

         // R6
         detach_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_detach[p] && !dev_attach[p] && port_words[p][P_EN] && !p_wr && !c_hcr)
            |=> (!port_words[p][P_EN] && port_words[p][P_ECHG] && !port_words[p][P_CONN]));
      end
   endgenerate
endmodule

bind usbh_portctl_regs usbh_regs_chk #(
   .NPORTS(NPORTS), .ADDR_W(ADDR_W), .REG_W(REG_W)
) i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_sel        (bus_sel),
   .bus_we         (bus_we),
   .bus_addr       (bus_addr),
   .bus_wdata      (bus_wdata),
   .dev_attach     (dev_attach),
   .dev_detach     (dev_detach),
   .dev_lowspeed   (dev_lowspeed),
   .cmd_q          (cmd_q),
   .sts_q          (sts_q),
   .port_words     (port_words),
   .port_reset_req (port_reset_req)
);

// File: tb/test_usbh_portctl_regs.sv
`timescale 1ns/1ps
module test_usbh_portctl_regs;
   localparam int NP = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_we = 1'b0;
   logic [15:0]   bus_addr = '0, bus_wdata = '0;
   logic [15:0]   bus_rdata;
   logic [NP-1:0] dev_attach = '0, dev_detach = '0, dev_lowspeed = '0;
   logic [3:0]    irq_enable = '0;
   logic [NP-1:0] port_reset_req;
   logic          irq;

   int n_tests = 0;
   int n_fail  = 0;

   logic [15:0] m_cmd, m_sts;
   logic [15:0] m_port [NP];

   always #2 clk = ~clk;

   usbh_portctl_regs i_usbh_portctl_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dev_attach(dev_attach), .dev_detach(dev_detach), .dev_lowspeed(dev_lowspeed),
      .irq_enable(irq_enable), .port_reset_req(port_reset_req), .irq(irq)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
      end
   endtask

   task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
      bus_addr = a;
      #0.2;
      chk(tag, bus_rdata, exp);
   endtask

   function automatic logic exp_irq();
      return |(m_sts[3:0] & irq_enable);
   endfunction

   // One bus/event cycle; called in the low clock phase.
   task automatic step(input logic we, input logic [15:0] a, input logic [15:0] wd,
                       input logic [NP-1:0] att, input logic [NP-1:0] det,
                       input logic [NP-1:0] ls);
      logic [4:0]    a5;
      logic [15:0]   ncmd, nsts;
      logic [15:0]   np [NP];
      logic [NP-1:0] pul;
      a5 = a[4:0];
      bus_sel = we; bus_we = we; bus_addr = a; bus_wdata = wd;
      dev_attach = att; dev_detach = det; dev_lowspeed = ls;
      ncmd = m_cmd; nsts = m_sts; pul = '0;
      for (int p = 0; p < NP; p++) np[p] = m_port[p];
      if (we && a5[4:1] == 4'd0 && wd[1]) begin
         ncmd = '0; nsts = '0;
         for (int p = 0; p < NP; p++) np[p] = '0;
      end else begin
         if (we && a5[4:1] == 4'd0) ncmd = {11'b0, wd[4:0]};
         if (we && a5[4:1] == 4'd1) nsts = m_sts & ~{12'b0, wd[3:0]};
         for (int p = 0; p < NP; p++) begin
            if (we && a5[4] && a5[3:1] == 3'(p)) begin
               pul[p] = wd[9] & ~m_port[p][9];
               np[p][2] = wd[2];
               np[p][9] = wd[9];
               if (wd[1]) np[p][1] = 1'b0;
               if (wd[3]) np[p][3] = 1'b0;
            end
            if (att[p]) begin
               np[p][0] = 1'b1; np[p][1] = 1'b1; np[p][8] = ls[p];
            end
            if (det[p]) begin
               np[p][0] = 1'b0; np[p][1] = 1'b1;
               if (np[p][2]) begin np[p][2] = 1'b0; np[p][3] = 1'b1; end
            end
         end
         if ((|att || |det) && m_cmd[3]) begin
            ncmd[4] = 1'b1; nsts[2] = 1'b1;
         end
      end
      @(posedge clk);
      m_cmd = ncmd; m_sts = nsts;
      for (int p = 0; p < NP; p++) m_port[p] = np[p];
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; dev_attach = '0; dev_detach = '0;
      chk("R4 reset pulse", {14'b0, port_reset_req}, {14'b0, pul});
      chk("R9 irq", {15'b0, irq}, {15'b0, exp_irq()});
      rd_chk("R3 cmd", 16'h0000, m_cmd);
      rd_chk("R7 status", 16'h0002, m_sts);
      rd_chk("R5 port0", 16'h0010, m_port[0]);
      rd_chk("R6 port1", 16'h0012, m_port[1]);
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] wd);
      step(1'b1, a, wd, '0, '0, '0);
   endtask

   task automatic ev(input logic [NP-1:0] att, input logic [NP-1:0] det, input logic [NP-1:0] ls);
      step(1'b0, 16'h0000, 16'h0000, att, det, ls);
   endtask

   initial begin
      #800000;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0A1C));
      m_cmd = '0; m_sts = '0;
      for (int p = 0; p < NP; p++) m_port[p] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", {15'b0, irq}, 16'h0);
      chk("R1 reset req", {14'b0, port_reset_req}, 16'h0);
      rd_chk("R1 cmd", 16'h0000, 16'h0000);
      rd_chk("R1 status", 16'h0002, 16'h0000);
      rd_chk("R1 port0", 16'h0010, 16'h0000);
      rd_chk("R1 port1", 16'h0012, 16'h0000);

      // R2 window decode
      rd_chk("R2 unmapped", 16'h0004, 16'hFFFF);
      rd_chk("R2 port index 2", 16'h0014, 16'hFFFF);
      rd_chk("R2 port index 7", 16'h001E, 16'hFFFF);
      wr(16'h0014, 16'h0204);
      rd_chk("R2 write ignored", 16'h0014, 16'hFFFF);
      wr(16'h0AE0, 16'h0001);
      rd_chk("R2 upper bits alias", 16'h0000, 16'h0001);
      rd_chk("R2 odd address", 16'h0011, m_port[0]);

      // R10 read-only port bits
      wr(16'h0010, 16'h0105);
      rd_chk("R10 port writable bits", 16'h0010, 16'h0004);

      // R4 rising-edge reset pulse
      wr(16'h0010, 16'h0200);
      chk("R4 stored reset", m_port[0], 16'h0200);
      wr(16'h0010, 16'h0200);
      wr(16'h0010, 16'h0000);
      wr(16'h0010, 16'h0200);
      wr(16'h0010, 16'h0000);

      // R5 attach
      ev(2'b10, 2'b00, 2'b10);
      rd_chk("R5 low-speed attach", 16'h0012, 16'h0103);
      ev(2'b01, 2'b00, 2'b00);
      rd_chk("R5 full-speed attach", 16'h0010, 16'h0003);

      // R6 detach
      wr(16'h0010, 16'h0004);
      ev(2'b00, 2'b01, 2'b00);
      rd_chk("R6 enabled detach", 16'h0010, 16'h000A);
      ev(2'b00, 2'b10, 2'b00);
      rd_chk("R6 disabled detach", 16'h0012, 16'h0102);

      // R8 write-1-clear on port change bits
      wr(16'h0010, 16'h0000);
      rd_chk("R8 zero keeps change", 16'h0010, 16'h000A);
      wr(16'h0010, 16'h000A);
      rd_chk("R8 port w1c", 16'h0010, 16'h0000);

      // R7 suspend wake, R9 irq
      irq_enable = 4'b0100;
      wr(16'h0000, 16'h0008);
      ev(2'b01, 2'b00, 2'b00);
      rd_chk("R7 force resume", 16'h0000, 16'h0018);
      rd_chk("R7 resume detect", 16'h0002, 16'h0004);
      chk("R9 irq raised", {15'b0, irq}, 16'h1);
      irq_enable = 4'b1011;
      #0.2;
      chk("R9 irq masked", {15'b0, irq}, 16'h0);
      irq_enable = 4'b0100;
      wr(16'h0002, 16'h0004);
      rd_chk("R8 status w1c", 16'h0002, 16'h0000);
      wr(16'h0000, 16'h0000);
      ev(2'b00, 2'b01, 2'b00);
      rd_chk("R7 no wake when awake", 16'h0000, 16'h0000);
      rd_chk("R7 no resume status", 16'h0002, 16'h0000);

      // R3 command readback and controller reset
      wr(16'h0000, 16'hFFFD);
      rd_chk("R3 cmd readback", 16'h0000, 16'h001D);
      ev(2'b10, 2'b00, 2'b00);
      wr(16'h0010, 16'h0004);
      wr(16'h0000, 16'h0002);
      rd_chk("R3 hc reset cmd", 16'h0000, 16'h0000);
      rd_chk("R3 hc reset status", 16'h0002, 16'h0000);
      rd_chk("R3 hc reset port0", 16'h0010, 16'h0000);
      rd_chk("R3 hc reset port1", 16'h0012, 16'h0000);

      // random mix
      for (int i = 0; i < 600; i++) begin
         int            kind;
         logic          we;
         logic [4:0]    a5;
         logic [15:0]   wd;
         logic [NP-1:0] att, det;
         kind = int'($urandom % 8);
         we = 1'b1;
         wd = 16'($urandom);
         a5 = 5'($urandom);
         case (kind)
            0: begin
               a5 = 5'h00;
               wd = {11'b0, wd[4:2], (($urandom % 12) == 0), wd[0]};
            end
            1: a5 = 5'h02;
            2, 3: a5 = {1'b1, 3'($urandom % 4), 1'b0};
            4: if (a5[4:1] == 4'd0) a5 = 5'h06;
            default: we = 1'b0;
         endcase
         if ($urandom % 8 == 0) irq_enable = 4'($urandom);
         att = ($urandom % 3 == 0) ? NP'($urandom) : '0;
         det = ($urandom % 3 == 0) ? (NP'($urandom) & ~att) : '0;
         step(we, {11'($urandom), a5}, wd, att, det, NP'($urandom));
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule